// File: doc/BRIEF.md
# Flash Row-Program and Page-Erase Sequencer

This block stands between a processor's register bus and an on-chip non-volatile array, modelled here as registers. Software fills a holding buffer one instruction word at a time. It then unlocks the block with a two-write key and starts one of three operations: program a whole row from the buffer, program a single word, or erase a page. While an operation runs, a stall output stays high for a fixed number of cycles per operation. The array changes only on the cycle the operation ends.

An instruction word is 24 bits wide and reaches the buffer through two bus writes. The first write carries bits 15:0 and is only latched. The second write carries bits 23:16 and commits the whole word. A row holds 64 words and a page holds 8 rows (512 words). Programming can only clear bits: the new data is ANDed into the array. Erase returns a whole page to all-ones. The bus uses word addressing, so a row starts at a multiple of 64 and a page at a multiple of 512. Illegal requests are dropped and set a sticky error flag, which software can read and clear.

Top module: `flash_seq`

## Requirements
- R1: After reset the control register (select 0) reads 0 (bit 15 = busy, bit 14 = error), `stall` is low, and every array word reads all-ones.
- R2: A start is accepted only if the two bus accesses immediately before it are writes of 0x0055 and then 0x00AA to the key register (select 1). A different value, or any read or write between the two key writes, breaks the unlock.
- R3: One unlock allows exactly one start. A second start without a fresh unlock is rejected.
- R4: A start (control write with bit 15 = 1, operation code in bits 1:0) is rejected when the block is not unlocked or the code is 3. A rejected start leaves `stall` low and the array unchanged, and it sets the error flag.
- R5: An accepted start raises `stall` and control bit 15 on the next cycle. They stay high for ROW_CYCLES (code 0, row program), WORD_CYCLES (code 1, word program) or ERASE_CYCLES (code 2, page erase) cycles and then clear by themselves.
- R6: Row program ANDs all 64 buffer entries into the row of the group the buffer was loaded from. The array changes only in the cycle the operation completes, and neighbouring rows are untouched.
- R7: Word program ANDs the most recently loaded buffer entry into the array at the address it was loaded from. No other word changes.
- R8: Page erase sets the 512 words of the page that starts at the pointer register (select 2) to all-ones. A pointer that is not a multiple of 512 makes the start rejected, with the error flag set and the array unchanged.
- R9: A write to select 3 latches bits 15:0 of a word. A write to select 4 commits {wdata[7:0], latched bits} into buffer entry pointer[5:0] and increments the pointer. A commit whose pointer lies in a different 64-aligned group than the first commit since the last invalidation is dropped, leaves the pointer alone and sets the error flag.
- R10: When a row or word program completes, the buffer is invalidated. A row or word program started with no loaded entry is rejected with the error flag set.
- R11: The key register (select 1) and the two data registers (selects 3 and 4) read as 0.
- R12: While busy, a start or a commit to select 4 is ignored and sets the error flag, and the operation in flight is not affected.
- R13: The error flag is sticky. Only a control write with bit 15 = 0 and bit 14 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 3 | Register select: 0 control, 1 key, 2 pointer, 3 data low, 4 data high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (counts as an access for the unlock) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| stall | output | 1 | High while an operation is in progress |
| arr_addr | input | 10 | Array observation address |
| arr_rdata | output | 24 | Array word at `arr_addr` (combinational) |

## Verification
Register reads and array reads are combinational, so they are due in the same cycle as their select or address. A write takes effect at the next rising edge. `stall` and control bit 15 rise one edge after an accepted start and fall exactly N edges later, and the array update lands on that same falling edge. The bench drives inputs just after each falling edge and samples at the following falling edge, half a cycle away from every rising edge. Each start is timed by counting, at falling edges, the cycles in which `stall` is high, and that count is compared with the configured duration.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int ROW_WORDS    = 64,
  parameter int PAGE_ROWS    = 8,
  parameter int NUM_PAGES    = 2,
  parameter int WORD_W       = 24,
  parameter int BUS_W        = 16,
  parameter int ROW_CYCLES   = 11064,
  parameter int WORD_CYCLES  = 2766,
  parameter int ERASE_CYCLES = 11064
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic [2:0]                                     bus_sel,
  input  logic                                           bus_wr,
  input  logic                                           bus_rd,
  input  logic [BUS_W-1:0]                               bus_wdata,
  output logic [BUS_W-1:0]                               bus_rdata,
  output logic                                           stall,
  input  logic [$clog2(ROW_WORDS*PAGE_ROWS*NUM_PAGES)-1:0] arr_addr,
  output logic [WORD_W-1:0]                              arr_rdata
);
  localparam int IDX_W = $clog2(ROW_WORDS);
  localparam int PAGE_WORDS = ROW_WORDS * PAGE_ROWS;
  localparam int PG_W = $clog2(PAGE_WORDS);
  localparam int DEPTH = PAGE_WORDS * NUM_PAGES;
  localparam int AW = $clog2(DEPTH);
  localparam int GRP_W = AW - IDX_W;
  localparam int HI_W = WORD_W - BUS_W;
  localparam int MAX_A = (ROW_CYCLES > WORD_CYCLES) ? ROW_CYCLES : WORD_CYCLES;
  localparam int MAX_C = (MAX_A > ERASE_CYCLES) ? MAX_A : ERASE_CYCLES;
  localparam int CNT_W = $clog2(MAX_C + 1);

  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_KEY = 3'd1, SEL_PTR = 3'd2,
                         SEL_LO = 3'd3, SEL_HI = 3'd4;
  localparam logic [1:0] OP_ROW = 2'd0, OP_WORD = 2'd1, OP_ERASE = 2'd2;

  typedef enum logic [1:0] {K_IDLE, K_HALF, K_OPEN} key_t;

  logic [WORD_W-1:0] mem  [DEPTH];
  logic [WORD_W-1:0] hbuf [ROW_WORDS];
  logic [BUS_W-1:0]  lo_q;
  logic [AW-1:0]     ptr;
  logic [GRP_W-1:0]  grp;
  logic              grp_vld;
  logic [IDX_W-1:0]  last_idx;
  logic [AW-PG_W-1:0] pg;
  logic              busy, err;
  logic [1:0]        op;
  logic [CNT_W-1:0]  cnt, load_cnt;
  key_t              key;

  wire       acc     = bus_wr | bus_rd;
  wire       wr_ctrl = bus_wr && bus_sel == SEL_CTRL;
  wire       go      = wr_ctrl && bus_wdata[BUS_W-1];
  wire       clr     = wr_ctrl && !bus_wdata[BUS_W-1] && bus_wdata[BUS_W-2];
  wire       wr_key  = bus_wr && bus_sel == SEL_KEY;
  wire       wr_hi   = bus_wr && bus_sel == SEL_HI;
  wire [1:0] req_op  = bus_wdata[1:0];
  wire       page_ok = ptr[PG_W-1:0] == '0;
  wire       op_ok   = (req_op == OP_ROW || req_op == OP_WORD) ? grp_vld :
                       (req_op == OP_ERASE) ? page_ok : 1'b0;
  wire       accept  = go && key == K_OPEN && !busy && op_ok;
  wire       grp_ok  = !grp_vld || ptr[AW-1:IDX_W] == grp;
  wire       load    = wr_hi && !busy && grp_ok;
  wire       fault   = (go && !accept) || (wr_hi && !load);
  wire       done    = busy && cnt == CNT_W'(1);

  assign stall     = busy;
  assign arr_rdata = mem[arr_addr];

  always_comb begin
    case (req_op)
      OP_ROW:  load_cnt = CNT_W'(ROW_CYCLES);
      OP_WORD: load_cnt = CNT_W'(WORD_CYCLES);
      default: load_cnt = CNT_W'(ERASE_CYCLES);
    endcase
  end

  always_comb begin
    case (bus_sel)
      SEL_CTRL: bus_rdata = {busy, err, {(BUS_W-2){1'b0}}};
      SEL_PTR:  bus_rdata = BUS_W'(ptr);
      default:  bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key <= K_IDLE;
    else if (acc) begin
      if (wr_key && bus_wdata == BUS_W'(16'h0055)) key <= K_HALF;
      else if (wr_key && bus_wdata == BUS_W'(16'h00AA) && key == K_HALF) key <= K_OPEN;
      else key <= K_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      op   <= OP_ROW;
      cnt  <= '0;
      pg   <= '0;
      err  <= 1'b0;
    end else begin
      if (accept) begin
        busy <= 1'b1;
        op   <= req_op;
        cnt  <= load_cnt;
        pg   <= ptr[AW-1:PG_W];
      end else if (done) busy <= 1'b0;
      else if (busy) cnt <= cnt - CNT_W'(1);
      if (fault) err <= 1'b1;
      else if (clr) err <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROW_WORDS; i++) hbuf[i] <= '1;
      lo_q     <= '0;
      ptr      <= '0;
      grp      <= '0;
      grp_vld  <= 1'b0;
      last_idx <= '0;
    end else begin
      if (done && op != OP_ERASE) begin
        for (int i = 0; i < ROW_WORDS; i++) hbuf[i] <= '1;
        grp_vld <= 1'b0;
      end
      if (bus_wr && bus_sel == SEL_PTR) ptr <= bus_wdata[AW-1:0];
      if (bus_wr && bus_sel == SEL_LO) lo_q <= bus_wdata;
      if (load) begin
        hbuf[ptr[IDX_W-1:0]] <= {bus_wdata[HI_W-1:0], lo_q};
        grp      <= ptr[AW-1:IDX_W];
        grp_vld  <= 1'b1;
        last_idx <= ptr[IDX_W-1:0];
        ptr      <= ptr + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= '1;
    end else if (done) begin
      case (op)
        OP_ROW:
          for (int i = 0; i < ROW_WORDS; i++)
            mem[{grp, i[IDX_W-1:0]}] <= mem[{grp, i[IDX_W-1:0]}] & hbuf[i];
        OP_WORD:
          mem[{grp, last_idx}] <= mem[{grp, last_idx}] & hbuf[last_idx];
        default:
          for (int j = 0; j < DEPTH; j++)
            if (j[AW-1:PG_W] == pg) mem[j] <= '1;
      endcase
    end
  end

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt > CNT_W'(1) |=> busy && cnt == $past(cnt) - CNT_W'(1));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cnt) == CNT_W'(1));

  // R2, R3
  unlock_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(key) == K_OPEN && key == K_IDLE);

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clr |=> err);

  // R6
  array_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $stable(arr_addr) |-> $stable(arr_rdata));
endmodule

// File: tb/test_flash_seq.sv
module test_flash_seq;
  localparam int RC = 40, WC = 12, EC = 60;
  localparam logic [23:0] ONES = 24'hFFFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_sel = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic stall;
  logic [9:0] arr_addr = '0;
  logic [23:0] arr_rdata;

  always #4 clk = ~clk;

  flash_seq #(.ROW_CYCLES(RC), .WORD_CYCLES(WC), .ERASE_CYCLES(EC)) i_flash_seq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall(stall),
    .arr_addr(arr_addr), .arr_rdata(arr_rdata));

  typedef struct {int kind; logic [23:0] act; logic [23:0] exp; string tag;} item_t;
  item_t sb[$];
  logic mon_go = 1'b0;
  int n_run = 0, n_fail = 0, busy_total = 0;
  bit wd = 1'b0;

  always @(negedge clk) if (stall) busy_total++;

  initial forever begin
    @(negedge clk);
    if (mon_go && sb.size() > 0) begin
      item_t it;
      logic [23:0] a;
      it = sb.pop_front();
      case (it.kind)
        0: a = arr_rdata;
        1: a = 24'(bus_rdata);
        2: a = 24'(stall);
        default: a = it.act;
      endcase
      n_run++;
      if (a !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, a, it.exp);
      end
    end
  end

  function automatic logic [23:0] pat(int i);
    return {8'(i * 5 + 17), 16'(16'hBEEF ^ (i * 257))};
  endfunction

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); #1;
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s);
    @(negedge clk); #1;
    bus_sel = s; bus_rd = 1'b1;
    @(negedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic push(input int kind, input int a, input logic [23:0] act,
                      input logic [23:0] e, input string tag);
    @(negedge clk); #1;
    if (kind == 0) arr_addr = 10'(a);
    else if (kind == 1) bus_sel = 3'(a);
    sb.push_back('{kind, act, e, tag});
    mon_go = 1'b1;
    @(negedge clk); #1;
    mon_go = 1'b0;
  endtask

  task automatic exp_arr(input int a, input logic [23:0] e, input string tag);
    push(0, a, '0, e, tag);
  endtask
  task automatic exp_reg(input int s, input logic [23:0] e, input string tag);
    push(1, s, '0, e, tag);
  endtask
  task automatic exp_stall(input logic e, input string tag);
    push(2, 0, '0, 24'(e), tag);
  endtask
  task automatic exp_eq(input int act, input int e, input string tag);
    push(3, 0, 24'(act), 24'(e), tag);
  endtask

  task automatic unlock();
    wr(3'd1, 16'h0055);
    wr(3'd1, 16'h00AA);
  endtask

  task automatic load_word(input logic [23:0] w);
    wr(3'd3, w[15:0]);
    wr(3'd4, {8'h00, w[23:16]});
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (stall) @(negedge clk);
    #1;
  endtask

  task automatic clear_err();
    wr(3'd0, 16'h4000);
  endtask

  task automatic run();
    int b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    exp_reg(0, 24'h0, "R1 control after reset");
    exp_stall(1'b0, "R1 stall after reset");
    exp_arr(0, ONES, "R1 array word 0");
    exp_arr(1023, ONES, "R1 array word 1023");

    wr(3'd2, 16'd64);
    for (int i = 0; i < 64; i++) load_word(pat(i));
    exp_reg(2, 24'd128, "R9 pointer advanced by loads");
    exp_reg(3, 24'h0, "R11 data low reads 0");
    exp_reg(4, 24'h0, "R11 data high reads 0");
    wr(3'd1, 16'h0055);
    exp_reg(1, 24'h0, "R11 key reads 0");
    wr(3'd1, 16'h00AA);
    b0 = busy_total;
    wr(3'd0, 16'h8000);
    exp_reg(0, 24'h8000, "R5 busy bit during row program");
    exp_stall(1'b1, "R5 stall during row program");
    exp_arr(64, ONES, "R6 array held until completion");
    wait_idle();
    exp_eq(busy_total - b0, RC, "R5 row program duration");
    exp_arr(64, pat(0), "R6 row word 0");
    exp_arr(69, pat(5), "R6 row word 5");
    exp_arr(127, pat(63), "R6 row word 63");
    exp_arr(128, ONES, "R6 next row untouched");
    exp_arr(63, ONES, "R6 previous row untouched");
    exp_reg(0, 24'h0, "R5 busy self-clears");

    unlock();
    wr(3'd0, 16'h8000);
    exp_stall(1'b0, "R10 row program with empty buffer");
    exp_reg(0, 24'h4000, "R10 error on empty buffer");
    clear_err();
    exp_reg(0, 24'h0, "R13 error cleared");

    wr(3'd2, 16'd200);
    load_word(24'h123456);
    unlock();
    b0 = busy_total;
    wr(3'd0, 16'h8001);
    wait_idle();
    exp_eq(busy_total - b0, WC, "R5 word program duration");
    exp_arr(200, 24'h123456, "R7 word programmed");
    exp_arr(201, ONES, "R7 neighbour untouched");
    wr(3'd2, 16'd200);
    load_word(24'h0F0F0F);
    unlock();
    wr(3'd0, 16'h8001);
    wait_idle();
    exp_arr(200, 24'h020406, "R7 program ANDs into array");

    unlock();
    wr(3'd0, 16'h8003);
    exp_reg(0, 24'h4000, "R4 operation code 3 rejected");
    clear_err();

    wr(3'd2, 16'd0);
    wr(3'd1, 16'h0055);
    wr(3'd1, 16'h0000);
    wr(3'd1, 16'h00AA);
    wr(3'd0, 16'h8002);
    exp_stall(1'b0, "R2 wrong second key value");
    exp_reg(0, 24'h4000, "R4 error on start without unlock");
    exp_arr(64, pat(0), "R4 array unchanged");
    clear_err();
    wr(3'd1, 16'h0055);
    rd(3'd0);
    wr(3'd1, 16'h00AA);
    wr(3'd0, 16'h8002);
    exp_reg(0, 24'h4000, "R2 access between key writes");
    clear_err();

    unlock();
    b0 = busy_total;
    wr(3'd0, 16'h8002);
    wait_idle();
    exp_eq(busy_total - b0, EC, "R5 page erase duration");
    exp_arr(64, ONES, "R8 page 0 erased at row 1");
    exp_arr(200, ONES, "R8 page 0 erased at word 200");
    wr(3'd0, 16'h8002);
    exp_stall(1'b0, "R3 second start without unlock");
    exp_reg(0, 24'h4000, "R3 unlock consumed");
    clear_err();

    wr(3'd2, 16'd600);
    load_word(24'h000000);
    unlock();
    wr(3'd0, 16'h8001);
    wait_idle();
    exp_arr(600, 24'h0, "R7 word 600 cleared");
    wr(3'd2, 16'd576);
    unlock();
    wr(3'd0, 16'h8002);
    exp_reg(0, 24'h4000, "R8 misaligned page rejected");
    exp_arr(600, 24'h0, "R8 array unchanged on misaligned erase");
    clear_err();
    wr(3'd2, 16'd512);
    unlock();
    wr(3'd0, 16'h8002);
    wait_idle();
    exp_arr(600, ONES, "R8 page 1 erased");

    wr(3'd2, 16'd128);
    load_word(pat(0));
    load_word(pat(1));
    wr(3'd2, 16'd300);
    load_word(24'h000000);
    exp_reg(0, 24'h4000, "R9 load from other group flagged");
    exp_reg(2, 24'd300, "R9 dropped load leaves pointer");
    clear_err();
    unlock();
    wr(3'd0, 16'h8000);
    wr(3'd0, 16'h8000);
    exp_reg(0, 24'hC000, "R12 start while busy flagged");
    clear_err();
    wr(3'd4, 16'h0000);
    exp_reg(0, 24'hC000, "R12 load while busy flagged");
    wait_idle();
    exp_arr(128, pat(0), "R9 first loaded word");
    exp_arr(129, pat(1), "R9 second loaded word");
    exp_arr(172, ONES, "R9 dropped load not in row");
    exp_arr(300, ONES, "R9 other group untouched");
    exp_reg(0, 24'h4000, "R13 error survives completion");
    clear_err();
    exp_reg(0, 24'h0, "R13 error cleared by write");
  endtask

  initial begin
    fork
      run();
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) $display("FAIL R5 watchdog: actual hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run + (wd ? 1 : 0), n_fail + (wd ? 1 : 0));
    $finish;
  end
endmodule